// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Flag Latch

This block connects an 8-bit A bus to a 9-bit B bus, where the B bus carries eight data bits and one parity bit. Two active-low output enables set the direction. With only the B-side enable low, the A word is driven onto B along with a generated parity bit that makes the count of ones odd. With only the A-side enable low, the B word is driven onto A, and the nine received bits are checked for odd parity. With both enables low, the A word still goes to B but the parity bit is inverted on purpose. This lets a system test its own error path. With both enables high, neither bus is driven. The data path passes values unchanged, without inversion.

The parity check result reaches the pin through a flag stage controlled by two active-low inputs. While latch-enable is low the stage is transparent. While it is high the stage holds the value sampled at the last clock edge. A low on clear forces the flag to no-error, and clear wins over latch-enable. Three-state buses appear as separate in, out and enable ports. The error pin is an open-drain pull-down, modelled as a constant-zero data output plus an enable. The board supplies a pull-up.

Top module: `ptx_parity_xcvr`

## Requirements
- R1: With oeb_n=0 and oea_n=1, b_oe and par_oe are 1, a_oe is 0, b_o equals a_i, and par_o makes the count of ones across b_o and par_o odd.
- R2: With oea_n=0 and oeb_n=1, a_oe is 1, b_oe and par_oe are 0, and a_o equals b_i.
- R3: With oea_n=0, oeb_n=1, le_n=0 and clr_n=1, err_oe is 1 (pin pulled low, error) when the count of ones in {par_i,b_i} is even, and 0 when it is odd.
- R4: With oea_n=0 and oeb_n=0, b_o equals a_i, b_oe and par_oe are 1, and par_o makes the count of ones across b_o and par_o even. With le_n=0 and clr_n=1 this raises err_oe.
- R5: With oea_n=1 and oeb_n=1, a_oe, b_oe and par_oe are all 0. With le_n=0 and clr_n=1, err_oe is 1 exactly when a_i holds an odd number of ones.
- R6: While le_n=0 and clr_n=1, err_oe follows the current check result in the same cycle, with no clock delay.
- R7: While le_n=1 and clr_n=1, err_oe keeps the value it showed at the last rising clock edge. New bus data and mode changes do not affect it.
- R8: clr_n=0 forces err_oe to 0 in the same cycle, overriding le_n=0. A rising clock edge during clear stores the no-error state.
- R9: rst_n=0 asynchronously sets the stored flag to no-error, so that with le_n=1 err_oe reads 0.
- R10: err_o is always 0, so the error pin is only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the error flag |
| rst_n | input | 1 | Asynchronous active-low reset of the stored flag |
| oea_n | input | 1 | Active-low enable of the A-side drivers |
| oeb_n | input | 1 | Active-low enable of the B-side drivers |
| le_n | input | 1 | Error flag transparent when low, holding when high |
| clr_n | input | 1 | Active-low clear of the error flag |
| a_i | input | DW | A bus value seen at the pins |
| a_o | output | DW | A bus drive value |
| a_oe | output | 1 | A bus driver enable |
| b_i | input | DW | B bus data seen at the pins |
| b_o | output | DW | B bus drive value |
| b_oe | output | 1 | B bus data driver enable |
| par_i | input | 1 | B bus parity bit seen at the pin |
| par_o | output | 1 | B bus parity drive value |
| par_oe | output | 1 | B bus parity driver enable |
| err_o | output | 1 | Error pin drive value, always 0 |
| err_oe | output | 1 | Error pin pull-down enable (1 = error shown) |

## Verification
Clear and transparent capture can land in the same cycle. The bench drives clr_n and le_n low together while a B word with an even ones count is on the bus. It expects the flag to stay released, and then to assert as soon as clear is lifted. The bench also checks that hold and clear work together: it holds an error flag while clean data and new modes arrive, then pulses clear with le_n high. The flag must drop at once and stay dropped after clear is released, which shows that the no-error state was stored.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  typedef enum logic [1:0] {
    XM_ISOLATE   = 2'd0,
    XM_A_TO_B    = 2'd1,
    XM_B_TO_A    = 2'd2,
    XM_FORCE_BAD = 2'd3
  } xmode_e;

  // Direction from the two active-low enables.
  function automatic xmode_e decode_mode(input logic oea_n, input logic oeb_n);
    case ({oea_n, oeb_n})
      2'b10:   return XM_A_TO_B;
      2'b01:   return XM_B_TO_A;
      2'b00:   return XM_FORCE_BAD;
      default: return XM_ISOLATE;
    endcase
  endfunction

endpackage

// File: rtl/ptx_mode_dec.sv
module ptx_mode_dec
  import ptx_pkg::*;
(
  input  logic   oea_n,
  input  logic   oeb_n,
  output xmode_e mode,
  output logic   drive_a,
  output logic   drive_b,
  output logic   invert_par
);

  always_comb begin
    mode       = decode_mode(oea_n, oeb_n);
    drive_a    = (mode == XM_B_TO_A);
    drive_b    = (mode == XM_A_TO_B) || (mode == XM_FORCE_BAD);
    invert_par = (mode == XM_FORCE_BAD);
  end

endmodule

// File: rtl/ptx_parity_unit.sv
module ptx_parity_unit
  import ptx_pkg::*;
#(
  parameter int DW = 8
) (
  input  xmode_e        mode,
  input  logic          invert_par,
  input  logic [DW-1:0] a_word,
  input  logic [DW-1:0] b_word,
  input  logic          b_par,
  output logic          par_gen,
  output logic          chk_ok
);

  localparam int CW = DW + 1;

  // Bit that completes an odd ones count over the word.
  function automatic logic odd_fill(input logic [DW-1:0] d);
    return ~(^d);
  endfunction

  // 1 when the word with its parity bit carries an odd ones count.
  function automatic logic odd_ok(input logic [CW-1:0] w);
    return ^w;
  endfunction

  logic [CW-1:0] driven_word;

  always_comb begin
    par_gen     = odd_fill(a_word) ^ invert_par;
    driven_word = {par_gen, a_word};
    case (mode)
      XM_B_TO_A:   chk_ok = odd_ok({b_par, b_word});
      XM_A_TO_B,
      XM_FORCE_BAD: chk_ok = odd_ok(driven_word);
      default:     chk_ok = ~(^a_word);
    endcase
  end

endmodule

// File: rtl/ptx_err_flag.sv
module ptx_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic le_n,
  input  logic clr_n,
  input  logic chk_ok,
  output logic flag_ok,
  output logic held_ok
);

  always_comb begin
    if (!clr_n)     flag_ok = 1'b1;
    else if (!le_n) flag_ok = chk_ok;
    else            flag_ok = held_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_ok <= 1'b1;
    else        held_ok <= flag_ok;
  end

endmodule

// File: rtl/ptx_parity_xcvr.sv
module ptx_parity_xcvr
  import ptx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oea_n,
  input  logic          oeb_n,
  input  logic          le_n,
  input  logic          clr_n,
  input  logic [DW-1:0] a_i,
  output logic [DW-1:0] a_o,
  output logic          a_oe,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] b_o,
  output logic          b_oe,
  input  logic          par_i,
  output logic          par_o,
  output logic          par_oe,
  output logic          err_o,
  output logic          err_oe
);

  xmode_e mode;
  logic   drive_a, drive_b, invert_par;
  logic   par_gen, chk_ok, flag_ok, held_ok;

  ptx_mode_dec u_dec (
    .oea_n(oea_n), .oeb_n(oeb_n), .mode(mode),
    .drive_a(drive_a), .drive_b(drive_b), .invert_par(invert_par)
  );

  ptx_parity_unit #(.DW(DW)) u_par (
    .mode(mode), .invert_par(invert_par), .a_word(a_i), .b_word(b_i),
    .b_par(par_i), .par_gen(par_gen), .chk_ok(chk_ok)
  );

  ptx_err_flag u_flag (
    .clk(clk), .rst_n(rst_n), .le_n(le_n), .clr_n(clr_n),
    .chk_ok(chk_ok), .flag_ok(flag_ok), .held_ok(held_ok)
  );

  assign a_o    = b_i;
  assign a_oe   = drive_a;
  assign b_o    = a_i;
  assign b_oe   = drive_b;
  assign par_o  = par_gen;
  assign par_oe = drive_b;
  assign err_o  = 1'b0;
  assign err_oe = ~flag_ok;

endmodule

// File: rtl/ptx_parity_xcvr_chk.sv
module ptx_parity_xcvr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oea_n,
  input logic          oeb_n,
  input logic          le_n,
  input logic          clr_n,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic          par_i,
  input logic [DW-1:0] a_o,
  input logic          a_oe,
  input logic [DW-1:0] b_o,
  input logic          b_oe,
  input logic          par_o,
  input logic          par_oe,
  input logic          err_oe
);

  p_gen_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!oeb_n && oea_n) |-> (b_oe && par_oe && !a_oe && (b_o == a_i) && (^{par_o, b_o})));

  p_b_to_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oea_n && oeb_n) |-> (a_oe && !b_oe && !par_oe && (a_o == b_i)));

  p_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oea_n && oeb_n && !le_n && clr_n) |-> (err_oe == ~(^{par_i, b_i})));

  p_force_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oea_n && !oeb_n) |-> (b_oe && par_oe && (b_o == a_i) && !(^{par_o, b_o})));

  p_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oea_n && oeb_n) |-> (!a_oe && !b_oe && !par_oe));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n && clr_n && $past(le_n && clr_n && rst_n)) |-> $stable(err_oe));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !err_oe);

endmodule

bind ptx_parity_xcvr ptx_parity_xcvr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oea_n(oea_n), .oeb_n(oeb_n), .le_n(le_n),
  .clr_n(clr_n), .a_i(a_i), .b_i(b_i), .par_i(par_i), .a_o(a_o),
  .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe), .par_o(par_o), .par_oe(par_oe),
  .err_oe(err_oe)
);

// File: tb/ptx_parity_xcvr_test.sv
module ptx_parity_xcvr_test;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, oea_n, oeb_n, le_n, clr_n, par_i;
  logic [DW-1:0] a_i, b_i;
  logic [DW-1:0] a_o, b_o;
  logic          a_oe, b_oe, par_o, par_oe, err_o, err_oe;
  wire           err_pin = err_oe ? err_o : 1'b1;  // board pull-up

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptx_parity_xcvr #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .oea_n(oea_n), .oeb_n(oeb_n), .le_n(le_n),
    .clr_n(clr_n), .a_i(a_i), .a_o(a_o), .a_oe(a_oe), .b_i(b_i), .b_o(b_o),
    .b_oe(b_oe), .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
    .err_o(err_o), .err_oe(err_oe)
  );

  function automatic int ones(input logic [DW-1:0] v);
    int n = 0;
    for (int i = 0; i < DW; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Fields: {oea_n, oeb_n, a[7:0], b[7:0], par}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {2'b10, 8'h00, 8'h00, 1'b0},
    {2'b10, 8'h01, 8'h00, 1'b0},
    {2'b10, 8'hFF, 8'h00, 1'b0},
    {2'b10, 8'hA7, 8'h00, 1'b0},
    {2'b01, 8'h00, 8'h00, 1'b1},
    {2'b01, 8'h00, 8'h00, 1'b0},
    {2'b01, 8'h00, 8'h3C, 1'b1},
    {2'b01, 8'h00, 8'h81, 1'b0},
    {2'b00, 8'h5A, 8'h00, 1'b0},
    {2'b00, 8'h07, 8'h00, 1'b0},
    {2'b11, 8'h13, 8'h00, 1'b0},
    {2'b11, 8'hC3, 8'h00, 1'b0}
  };

  task automatic apply_b_to_a(input logic [DW-1:0] b, input logic p);
    @(negedge clk);
    oea_n = 1'b0; oeb_n = 1'b1; b_i = b; par_i = p;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; oea_n = 1; oeb_n = 1; le_n = 1; clr_n = 1;
    a_i = '0; b_i = '0; par_i = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset err_oe", err_oe, 0);
    chk("R5 reset enables", {a_oe, b_oe, par_oe}, 0);
    @(negedge clk); rst_n = 1; le_n = 0;

    // Table walk, transparent flag
    for (int k = 0; k < NV; k++) begin
      logic [18:0] v = VEC[k];
      @(negedge clk);
      {oea_n, oeb_n, a_i, b_i, par_i} = v;
      #1;
      case ({oea_n, oeb_n})
        2'b10: begin
          chk("R1 enables", {a_oe, b_oe, par_oe}, 3'b011);
          chk("R1 data", b_o, a_i);
          chk("R1 parity", par_o, (ones(a_i) % 2 == 0));
          chk("R1 no error", err_oe, 0);
        end
        2'b01: begin
          chk("R2 enables", {a_oe, b_oe, par_oe}, 3'b100);
          chk("R2 data", a_o, b_i);
          chk("R3 check", err_oe, ((ones(b_i) + par_i) % 2 == 0));
        end
        2'b00: begin
          chk("R4 data", b_o, a_i);
          chk("R4 inverted parity", par_o, (ones(a_i) % 2 == 1));
          chk("R4 forced error", err_oe, 1);
        end
        default: begin
          chk("R5 enables", {a_oe, b_oe, par_oe}, 0);
          chk("R5 isolate flag", err_oe, (ones(a_i) % 2 == 1));
        end
      endcase
      chk("R10 pin", {err_o, err_pin}, {1'b0, ~err_oe});
    end

    // Random B words, clean then one flipped bit
    for (int k = 0; k < 24; k++) begin
      logic [DW-1:0] w = DW'($urandom);
      logic gp = (ones(w) % 2 == 0);
      int bp = $urandom_range(0, DW);
      apply_b_to_a(w, gp);
      chk("R3 clean word", err_oe, 0);
      if (bp == DW) apply_b_to_a(w, ~gp);
      else          apply_b_to_a(w ^ (DW'(1) << bp), gp);
      chk("R3 single flip", err_oe, 1);
      chk("R6 same-cycle error", err_pin, 0);
    end
    apply_b_to_a(8'h0F, 1'b1);
    chk("R6 follows clean", err_oe, 0);

    // Hold across new data and modes
    apply_b_to_a(8'h0F, 1'b0);
    chk("R6 bad captured", err_oe, 1);
    @(negedge clk); le_n = 1; b_i = 8'h0F; par_i = 1; #1;
    chk("R7 hold over clean data", err_oe, 1);
    @(negedge clk); oea_n = 1; oeb_n = 0; a_i = 8'h00; #1;
    chk("R7 hold over mode change", err_oe, 1);
    @(negedge clk); oea_n = 0; oeb_n = 1; #1;
    chk("R7 hold later", err_oe, 1);

    // Clear with le_n high, then release
    @(negedge clk); clr_n = 0; #1;
    chk("R8 clear immediate", err_oe, 0);
    @(negedge clk); clr_n = 1; #1;
    chk("R8 clear stored", err_oe, 0);

    // Clear and transparent capture in the same cycle
    @(negedge clk); le_n = 0; clr_n = 0; b_i = 8'h0F; par_i = 0; #1;
    chk("R8 clear over le", err_oe, 0);
    @(negedge clk); clr_n = 1; #1;
    chk("R6 after clear lifts", err_oe, 1);

    // Reset wipes a held error
    @(negedge clk); le_n = 1; #1;
    chk("R7 held before reset", err_oe, 1);
    @(negedge clk); rst_n = 0; #1;
    chk("R9 async reset", err_oe, 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R9 stays clear", err_oe, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule